// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates interrupt requests for a small microcontroller core. Five event sources feed it: two external request lines, a low-level port input, a timer overflow and a comparator event. Each event sets a pending flag. Each source has its own enable bit, and one global enable gates them all. The highest-priority request that is both pending and enabled is offered to the core as a vector index. Each vector occupies one program word, so the vector address is the index itself.

The core accepts a request with a one-cycle acknowledge. On that edge the block clears the serviced flag and the global enable, which masks any further interrupt. A return indication from the core sets the global enable again. A handler may also set it by register write, which allows nested interrupts. Software reads both registers and writes the enables. It clears flags by writing ones to them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Reset clears all flags, all source enables and the global enable. While no request is offered, irqVector and irqAddr read 0, which is the reset vector and cannot be masked.
- R2: A 1 on bit i of evtIn sets flag i on the next edge, whatever the enables hold. Flag bits are 0 = external 0, 1 = external 1, 2 = port low level, 3 = timer overflow and 4 = comparator.
- R3: irqValid is 1 only when the global enable is 1 and at least one flag is set whose enable bit is also set.
- R4: When several sources qualify, the lowest flag bit wins. The offered index is the bit position plus one, giving vectors 1 to 5. irqAddr carries the same value, zero-extended.
- R5: When irqAck is high while irqValid is high, the next edge clears the global enable and the winning flag. All other flags are left as they were.
- R6: retiPulse sets the global enable on the next edge.
- R7: Writing 1 to the global enable bit (bit 5 of register 0) while a handler runs lets a pending request raise irqValid again.
- R8: Register 1 holds the flags. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: An event that arrives in the same cycle as a clear of that flag, whether by acknowledge or by write, leaves the flag set.
- R10: Register 0 reads {global enable, enables[4:0]}. Register 1 reads {0, flags[4:0]}. Addresses 2 and 3 read 0.
- R11: In one cycle the global enable follows this priority: an acknowledge clears it first, then a return sets it, and a register 0 write applies only when neither occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 5 | Source event pulses, one bit per source |
| irqAck | input | 1 | Core accepts the offered vector |
| retiPulse | input | 1 | Core returned from a handler |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 6 | Register write data |
| regRdata | output | 6 | Register read data (combinational) |
| irqValid | output | 1 | A request is offered |
| irqVector | output | 3 | Offered vector index, 0 when idle |
| irqAddr | output | 12 | Offered vector word address |

## Verification
Every state change lands on the first rising edge after its stimulus. irqValid, irqVector, irqAddr and regRdata are combinational from that state, so each result is due exactly one edge after the cycle in which the input was applied. Register reads are due in the same cycle as the address. The bench drives on the falling edge, lets one rising edge pass, and samples on the next falling edge. When two inputs must collide, such as an event with an acknowledge or a return with a write, they are driven in the same cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int RA_W = 2;
  localparam logic [RA_W-1:0] ADDR_ENABLE = 2'd0;
  localparam logic [RA_W-1:0] ADDR_FLAGS  = 2'd1;

  typedef struct packed {
    logic take;     // acknowledged request this cycle
    logic retiSet;  // return from handler
    logic enWr;     // write to enable register
    logic flagWr;   // write-one-to-clear on flags
  } picStrobe_t;
endpackage

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
#(
  parameter int NSRC  = 5,
  parameter int IDX_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]  flagQ,
  input  logic [NSRC-1:0]  enQ,
  input  logic             gieQ,
  input  logic             irqAck,
  input  logic             retiPulse,
  input  logic             regWe,
  input  logic [RA_W-1:0]  regAddr,
  output picStrobe_t       strb,
  output logic [NSRC-1:0]  ackMask,
  output logic             irqValid,
  output logic [IDX_W-1:0] irqVector
);
  logic [NSRC-1:0]  pending;
  logic [NSRC-1:0]  winMask;
  logic [IDX_W-1:0] winIdx;

  assign pending = flagQ & enQ;

  // lowest bit wins: scan downward so the last hit is the lowest
  always_comb begin
    winIdx  = '0;
    winMask = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        winIdx  = IDX_W'(i + 1);
        winMask = NSRC'(1) << i;
      end
    end
  end

  assign irqValid  = gieQ & (|pending);
  assign irqVector = irqValid ? winIdx : '0;

  always_comb begin
    strb.take    = irqValid & irqAck;
    strb.retiSet = retiPulse;
    strb.enWr    = regWe && (regAddr == ADDR_ENABLE);
    strb.flagWr  = regWe && (regAddr == ADDR_FLAGS);
  end

  assign ackMask = strb.take ? winMask : '0;
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NSRC = 5,
  parameter int RW   = NSRC + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  picStrobe_t      strb,
  input  logic [NSRC-1:0] ackMask,
  input  logic [NSRC-1:0] evtIn,
  input  logic [RA_W-1:0] regAddr,
  input  logic [RW-1:0]   regWdata,
  output logic [NSRC-1:0] flagQ,
  output logic [NSRC-1:0] enQ,
  output logic            gieQ,
  output logic [RW-1:0]   regRdata
);
  localparam int GIE_BIT = RW - 1;

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    logic clrBit;
    assign clrBit = ackMask[g] | (strb.flagWr & regWdata[g]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[g] <= 1'b0;
      else       flagQ[g] <= evtIn[g] | (flagQ[g] & ~clrBit);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          enQ <= '0;
    else if (strb.enWr) enQ <= regWdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             gieQ <= 1'b0;
    else if (strb.take)    gieQ <= 1'b0;
    else if (strb.retiSet) gieQ <= 1'b1;
    else if (strb.enWr)    gieQ <= regWdata[GIE_BIT];
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_ENABLE: begin
        regRdata[NSRC-1:0] = enQ;
        regRdata[GIE_BIT]  = gieQ;
      end
      ADDR_FLAGS: regRdata[NSRC-1:0] = flagQ;
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NSRC   = 5,
  parameter int ADDR_W = 12,
  parameter int RW     = NSRC + 1,
  parameter int IDX_W  = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   evtIn,
  input  logic              irqAck,
  input  logic              retiPulse,
  input  logic              regWe,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [RW-1:0]     regWdata,
  output logic [RW-1:0]     regRdata,
  output logic              irqValid,
  output logic [IDX_W-1:0]  irqVector,
  output logic [ADDR_W-1:0] irqAddr
);
  picStrobe_t      strb;
  logic [NSRC-1:0] flagQ;
  logic [NSRC-1:0] enQ;
  logic [NSRC-1:0] ackMask;
  logic            gieQ;

  pic_control #(.NSRC(NSRC), .IDX_W(IDX_W)) u_ctrl (
    .flagQ(flagQ), .enQ(enQ), .gieQ(gieQ),
    .irqAck(irqAck), .retiPulse(retiPulse),
    .regWe(regWe), .regAddr(regAddr),
    .strb(strb), .ackMask(ackMask),
    .irqValid(irqValid), .irqVector(irqVector)
  );

  pic_datapath #(.NSRC(NSRC), .RW(RW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ackMask(ackMask),
    .evtIn(evtIn), .regAddr(regAddr), .regWdata(regWdata),
    .flagQ(flagQ), .enQ(enQ), .gieQ(gieQ), .regRdata(regRdata)
  );

  // one program word per vector, table based at word 0
  assign irqAddr = ADDR_W'(irqVector);
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int NSRC  = 5,
  parameter int IDX_W = $clog2(NSRC + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [NSRC-1:0]  evtIn,
  input logic             irqAck,
  input logic             retiPulse,
  input logic             irqValid,
  input logic [IDX_W-1:0] irqVector,
  input logic [NSRC-1:0]  flagQ,
  input logic [NSRC-1:0]  enQ,
  input logic             gieQ,
  input logic [NSRC-1:0]  ackMask
);
  p_flag_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((flagQ & $past(evtIn)) == $past(evtIn)));

  p_valid_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (gieQ && ((flagQ & enQ) != '0)));

  p_vec_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqVector >= IDX_W'(1) && irqVector <= IDX_W'(NSRC)));

  p_idle_vec_r1: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> (irqVector == '0));

  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackMask));

  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && irqAck) |=> (!gieQ && ((flagQ & $past(ackMask & ~evtIn)) == '0)));

  p_reti_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (retiPulse && !(irqValid && irqAck)) |=> gieQ);
endmodule

bind prio_irq_ctrl pic_checker #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .irqAck(irqAck),
  .retiPulse(retiPulse), .irqValid(irqValid), .irqVector(irqVector),
  .flagQ(flagQ), .enQ(enQ), .gieQ(gieQ), .ackMask(ackMask)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] evtIn = '0;
  logic       irqAck = 1'b0;
  logic       retiPulse = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [5:0] regWdata = '0;
  logic [5:0] regRdata;
  logic       irqValid;
  logic [2:0] irqVector;
  logic [11:0] irqAddr;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .irqAck(irqAck),
    .retiPulse(retiPulse), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqValid(irqValid),
    .irqVector(irqVector), .irqAddr(irqAddr)
  );

  // {evt[4:0], enableReg[5:0], expValid, expVector[2:0]}
  localparam logic [14:0] TBL [9] = '{
    {5'b00001, 6'h21, 1'b1, 3'd1},
    {5'b11111, 6'h3F, 1'b1, 3'd1},
    {5'b11110, 6'h3F, 1'b1, 3'd2},
    {5'b11000, 6'h3F, 1'b1, 3'd4},
    {5'b10000, 6'h30, 1'b1, 3'd5},
    {5'b11111, 6'h1F, 1'b0, 3'd0},
    {5'b00101, 6'h24, 1'b1, 3'd3},
    {5'b01011, 6'h20, 1'b0, 3'd0},
    {5'b00110, 6'h39, 1'b0, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, applied at a falling edge, released at the next
  task automatic cyc(input logic [4:0] e, input logic ack, input logic ret,
                     input logic we, input logic [1:0] a, input logic [5:0] d);
    evtIn = e; irqAck = ack; retiPulse = ret; regWe = we; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    evtIn = '0; irqAck = 1'b0; retiPulse = 1'b0; regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [5:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      nVec++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] r;
    @(negedge clk);
    @(negedge clk);
    // R1: state while reset is held and right after release
    chk("R1 valid in reset", irqValid, 0);
    chk("R1 vector in reset", irqVector, 0);
    rstN = 1'b1;
    @(negedge clk);
    rd(2'd0, r); chk("R1 enable reg after reset", r, 6'h00);
    rd(2'd1, r); chk("R1 flag reg after reset", r, 6'h00);
    chk("R1 addr after reset", irqAddr, 0);

    // table walk: R2 R3 R4
    for (int i = 0; i < 9; i++) begin
      logic [4:0] e;
      logic [5:0] en;
      e  = TBL[i][14:10];
      en = TBL[i][9:4];
      cyc(5'b0, 1'b0, 1'b0, 1'b1, 2'd0, 6'h00);
      cyc(5'b0, 1'b0, 1'b0, 1'b1, 2'd1, 6'h1F);
      cyc(e, 1'b0, 1'b0, 1'b0, 2'd0, 6'h00);
      cyc(5'b0, 1'b0, 1'b0, 1'b1, 2'd0, en);
      rd(2'd1, r); chk("R2 flags latched", r, {1'b0, e});
      chk("R3 valid gating", irqValid, TBL[i][3]);
      chk("R4 priority vector", irqVector, TBL[i][2:0]);
      chk("R4 vector address", irqAddr, {9'b0, TBL[i][2:0]});
    end

    // R1: reset in mid-run wipes flags and enables
    rstN = 1'b0;
    @(negedge clk);
    rd(2'd1, r); chk("R1 flags cleared by reset", r, 6'h00);
    rd(2'd0, r); chk("R1 enables cleared by reset", r, 6'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R5: acknowledge clears winner and global enable only
    cyc(5'b0, 1'b0, 1'b0, 1'b1, 2'd0, 6'h3F);
    cyc(5'b00110, 1'b0, 1'b0, 1'b0, 2'd0, 6'h00);
    chk("R4 vector ext1", irqVector, 2);
    cyc(5'b0, 1'b1, 1'b0, 1'b0, 2'd0, 6'h00);
    rd(2'd1, r); chk("R5 only winner flag cleared", r, 6'h04);
    rd(2'd0, r); chk("R5 global enable cleared", r, 6'h1F);
    chk("R5 masked after ack", irqValid, 0);

    // R7: nesting by software re-enable
    cyc(5'b0, 1'b0, 1'b0, 1'b1, 2'd0, 6'h3F);
    chk("R7 valid after re-enable", irqValid, 1);
    chk("R7 vector port low", irqVector, 3);

    // R6: return sets global enable
    cyc(5'b0, 1'b1, 1'b0, 1'b0, 2'd0, 6'h00);
    cyc(5'b00001, 1'b0, 1'b0, 1'b0, 2'd0, 6'h00);
    chk("R3 masked while global off", irqValid, 0);
    cyc(5'b0, 1'b0, 1'b1, 1'b0, 2'd0, 6'h00);
    chk("R6 valid after return", irqValid, 1);
    rd(2'd0, r); chk("R6 global enable set", r, 6'h3F);

    // R9: event together with acknowledge keeps the flag
    cyc(5'b00001, 1'b1, 1'b0, 1'b0, 2'd0, 6'h00);
    rd(2'd1, r); chk("R9 event beats ack clear", r, 6'h01);
    rd(2'd0, r); chk("R5 ack still drops global", r, 6'h1F);

    // R8: write-one-to-clear
    cyc(5'b11000, 1'b0, 1'b0, 1'b0, 2'd0, 6'h00);
    cyc(5'b0, 1'b0, 1'b0, 1'b1, 2'd1, 6'h09);
    rd(2'd1, r); chk("R8 w1c partial", r, 6'h10);

    // R9: event together with w1c keeps the flag
    cyc(5'b10000, 1'b0, 1'b0, 1'b1, 2'd1, 6'h10);
    rd(2'd1, r); chk("R9 event beats w1c", r, 6'h10);

    // R11: ack beats return, return beats write
    cyc(5'b0, 1'b0, 1'b1, 1'b0, 2'd0, 6'h00);
    chk("R4 vector comparator", irqVector, 5);
    cyc(5'b0, 1'b1, 1'b1, 1'b0, 2'd0, 6'h00);
    rd(2'd0, r); chk("R11 ack over return", r, 6'h1F);
    rd(2'd1, r); chk("R5 comparator flag cleared", r, 6'h00);
    cyc(5'b0, 1'b0, 1'b1, 1'b1, 2'd0, 6'h1F);
    rd(2'd0, r); chk("R11 return over write", r, 6'h3F);

    // R10: unused addresses
    rd(2'd2, r); chk("R10 addr2 reads zero", r, 6'h00);
    rd(2'd3, r); chk("R10 addr3 reads zero", r, 6'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule